// File: doc/BRIEF.md
# Inter-Processor Interrupt Target Resolver

This block turns one inter-processor interrupt command into the set of processors that receive it and into the action each of them takes. It serves a system of up to `NCPU` local interrupt controllers. Every controller slot is described by four table inputs: a populated flag, a physical ID byte, a logical ID byte and a 4-bit addressing format. The sender supplies its own slot index and the two 32-bit command words. Writing the low command word starts a resolution.

One clock edge after the write strobe, the block raises a single-cycle valid strobe. With that strobe it presents the target mask, the vector and the trigger bit. It also drives one per-processor pulse vector for each action: set a fixed vector, system-management interrupt, non-maskable interrupt, INIT, startup (the vector is the startup vector) and arbitration-ID sync. Lowest-priority delivery is narrowed to a single processor, the lowest-indexed one that matched. An INIT that carries a level-deassert encoding delivers nothing and only pulses the arbitration-ID sync.

Top module: `ipi_target_resolver`

## Requirements
- R1: A write strobe `cmd_lo_we` sampled at a rising edge makes `res_valid` high for exactly the following cycle. While it is high, `res_vector` carries low-word bits [7:0] and `res_trig` carries low-word bit [15].
- R2: Shorthand field, low-word bits [19:18]: value 1 targets only the sender (`self_idx`). Value 2 targets every populated slot. Value 3 targets every populated slot except the sender.
- R3: With shorthand 0 and destination-mode bit [11] = 0 (physical), a destination byte (high-word bits [31:24]) of 0xFF targets every populated slot. Any other value targets the lowest-indexed populated slot whose physical ID equals it, or no slot at all.
- R4: With shorthand 0 and bit [11] = 1 (logical), a slot with format 4'hF matches when the bitwise AND of the destination and its logical ID is nonzero.
- R5: In logical mode, a slot with format 4'h0 matches when the upper nibbles of the destination and the logical ID are equal and their lower nibbles share a set bit. A slot with any other format value never matches.
- R6: A slot whose `cpu_present` bit is 0 never appears in `res_mask` or in any action vector.
- R7: Delivery mode, low-word bits [10:8], selects one action vector, which then equals `res_mask`: 0 selects `act_fixed`, 2 `act_smi`, 4 `act_nmi`, 5 `act_init` and 6 `act_start`. Codes 3 and 7 raise no action.
- R8: Delivery mode 1 (lowest priority) reduces `res_mask` to the lowest-indexed bit of the resolved set and drives `act_fixed` with that same single bit.
- R9: Delivery mode 5 with level bit [14] = 0 and trigger bit [15] = 1 raises no `act_init`. It drives `act_arbsync` equal to `res_mask`.
- R10: When `res_valid` is low, and during reset, `res_mask`, `res_vector`, `res_trig` and all action vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_lo_we | input | 1 | Write strobe for the low command word; starts a resolution |
| cmd_lo | input | 32 | Low command word (vector, mode, dest mode, level, trigger, shorthand) |
| cmd_hi | input | 32 | High command word; destination byte in [31:24] |
| self_idx | input | IDX_W | Slot index of the sending processor |
| cpu_present | input | NCPU | Populated flag per slot |
| cpu_phys_id | input | NCPU*8 | Physical ID per slot, slot i in bits [8i+7:8i] |
| cpu_log_id | input | NCPU*8 | Logical ID per slot, slot i in bits [8i+7:8i] |
| cpu_fmt | input | NCPU*4 | Logical addressing format per slot, slot i in bits [4i+3:4i] |
| res_valid | output | 1 | One-cycle result strobe |
| res_mask | output | NCPU | Resolved target slots |
| res_vector | output | 8 | Vector of the command (startup vector for mode 6) |
| res_trig | output | 1 | Trigger bit of the command |
| act_fixed | output | NCPU | Per-slot set-vector pulse |
| act_smi | output | NCPU | Per-slot system-management interrupt pulse |
| act_nmi | output | NCPU | Per-slot non-maskable interrupt pulse |
| act_init | output | NCPU | Per-slot INIT pulse |
| act_start | output | NCPU | Per-slot startup pulse |
| act_arbsync | output | NCPU | Per-slot arbitration-ID sync pulse |

## Verification
The bench sweeps all 256 destination bytes under every shorthand and both destination modes, on two slot tables. The first table is fully populated and holds a duplicated physical ID, with flat and cluster logical entries; it separates first-match physical lookup from broadcast and flat matching from cluster matching. The second table has an empty slot and an unknown format; it shows that such slots never leak into the mask. Delivery mode, level and trigger rotate with the destination, so every action code, the lowest-priority narrowing and the level-deassert INIT are met with many different masks. Directed commands pin the strobe timing and the quiet state between results.

// File: rtl/ipi_resolver_pkg.sv
package ipi_resolver_pkg;

  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int DMODE_BIT = 11;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_RSV7   = 3'd7
  } dlv_mode_e;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

endpackage

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // isolate lowest set bit
  assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
  parameter int NCPU  = 4,
  parameter int ID_W  = 8,
  parameter int FMT_W = 4
) (
  input  logic [ID_W-1:0]       dest,
  input  logic                  logical,
  input  logic [NCPU-1:0]       present,
  input  logic [NCPU*ID_W-1:0]  phys_tbl,
  input  logic [NCPU*ID_W-1:0]  log_tbl,
  input  logic [NCPU*FMT_W-1:0] fmt_tbl,
  output logic [NCPU-1:0]       hit
);
  localparam int NIB = ID_W / 2;
  localparam logic [FMT_W-1:0] FMT_FLAT    = '1;
  localparam logic [FMT_W-1:0] FMT_CLUSTER = '0;

  logic [NCPU-1:0] phys_raw;
  logic [NCPU-1:0] phys_first;
  logic [NCPU-1:0] log_hit;

  for (genvar i = 0; i < NCPU; i++) begin : g_slot
    logic [ID_W-1:0]  pid;
    logic [ID_W-1:0]  lid;
    logic [FMT_W-1:0] fmt;
    assign pid = phys_tbl[i*ID_W +: ID_W];
    assign lid = log_tbl[i*ID_W +: ID_W];
    assign fmt = fmt_tbl[i*FMT_W +: FMT_W];
    assign phys_raw[i] = present[i] && (pid == dest);

    always_comb begin
      log_hit[i] = 1'b0;
      if (fmt == FMT_FLAT) begin
        log_hit[i] = |(dest & lid);
      end else if (fmt == FMT_CLUSTER) begin
        log_hit[i] = (dest[ID_W-1:NIB] == lid[ID_W-1:NIB]) &&
                     (|(dest[NIB-1:0] & lid[NIB-1:0]));
      end
    end
  end

  ipi_lowest_pick #(.N(NCPU)) u_first (
    .req (phys_raw),
    .gnt (phys_first)
  );

  always_comb begin
    if (logical) begin
      hit = log_hit & present;
    end else if (dest == '1) begin
      hit = present;
    end else begin
      hit = phys_first;
    end
  end
endmodule

// File: rtl/ipi_action_dec.sv
module ipi_action_dec
  import ipi_resolver_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [NCPU-1:0] tgt,
  input  dlv_mode_e       mode,
  input  logic            level,
  input  logic            trig,
  output logic [NCPU-1:0] fixed_m,
  output logic [NCPU-1:0] smi_m,
  output logic [NCPU-1:0] nmi_m,
  output logic [NCPU-1:0] init_m,
  output logic [NCPU-1:0] start_m,
  output logic [NCPU-1:0] arbsync_m
);
  logic deassert;
  assign deassert = !level && trig;

  always_comb begin
    fixed_m   = '0;
    smi_m     = '0;
    nmi_m     = '0;
    init_m    = '0;
    start_m   = '0;
    arbsync_m = '0;
    unique case (mode)
      DM_FIXED, DM_LOWEST: fixed_m = tgt;
      DM_SMI:              smi_m   = tgt;
      DM_NMI:              nmi_m   = tgt;
      DM_INIT: begin
        if (deassert) arbsync_m = tgt;
        else          init_m    = tgt;
      end
      DM_START:            start_m = tgt;
      default: ;
    endcase
  end
endmodule

// File: rtl/ipi_target_resolver.sv
module ipi_target_resolver
  import ipi_resolver_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_lo_we,
  input  logic [31:0]       cmd_lo,
  input  logic [31:0]       cmd_hi,
  input  logic [IDX_W-1:0]  self_idx,
  input  logic [NCPU-1:0]   cpu_present,
  input  logic [NCPU*8-1:0] cpu_phys_id,
  input  logic [NCPU*8-1:0] cpu_log_id,
  input  logic [NCPU*4-1:0] cpu_fmt,
  output logic              res_valid,
  output logic [NCPU-1:0]   res_mask,
  output logic [7:0]        res_vector,
  output logic              res_trig,
  output logic [NCPU-1:0]   act_fixed,
  output logic [NCPU-1:0]   act_smi,
  output logic [NCPU-1:0]   act_nmi,
  output logic [NCPU-1:0]   act_init,
  output logic [NCPU-1:0]   act_start,
  output logic [NCPU-1:0]   act_arbsync
);
  localparam int ID_W  = 8;
  localparam int FMT_W = 4;

  // command field decode
  logic [7:0]  c_vec;
  dlv_mode_e   c_mode;
  logic        c_logical;
  logic        c_level;
  logic        c_trig;
  shorthand_e  c_sh;
  logic [ID_W-1:0] c_dest;

  assign c_vec     = cmd_lo[VEC_LSB +: 8];
  assign c_mode    = dlv_mode_e'(cmd_lo[MODE_LSB +: 3]);
  assign c_logical = cmd_lo[DMODE_BIT];
  assign c_level   = cmd_lo[LEVEL_BIT];
  assign c_trig    = cmd_lo[TRIG_BIT];
  assign c_sh      = shorthand_e'(cmd_lo[SH_LSB +: 2]);
  assign c_dest    = cmd_hi[DEST_LSB +: ID_W];

  logic unused_bits;
  assign unused_bits = ^{cmd_lo[31:20], cmd_lo[17:16], cmd_lo[13:12], cmd_hi[23:0]};

  // destination set
  logic [NCPU-1:0] field_hit;
  logic [NCPU-1:0] self_oh;
  logic [NCPU-1:0] sel_set;
  logic [NCPU-1:0] low_one;
  logic [NCPU-1:0] tgt;

  assign self_oh = NCPU'(1) << self_idx;

  ipi_dest_match #(.NCPU(NCPU), .ID_W(ID_W), .FMT_W(FMT_W)) u_match (
    .dest     (c_dest),
    .logical  (c_logical),
    .present  (cpu_present),
    .phys_tbl (cpu_phys_id),
    .log_tbl  (cpu_log_id),
    .fmt_tbl  (cpu_fmt),
    .hit      (field_hit)
  );

  always_comb begin
    unique case (c_sh)
      SH_FIELD:  sel_set = field_hit;
      SH_SELF:   sel_set = self_oh & cpu_present;
      SH_ALL:    sel_set = cpu_present;
      SH_OTHERS: sel_set = cpu_present & ~self_oh;
      default:   sel_set = '0;
    endcase
  end

  ipi_lowest_pick #(.N(NCPU)) u_lowest (
    .req (sel_set),
    .gnt (low_one)
  );

  assign tgt = (c_mode == DM_LOWEST) ? low_one : sel_set;

  logic [NCPU-1:0] fx_d, smi_d, nmi_d, ini_d, st_d, arb_d;

  ipi_action_dec #(.NCPU(NCPU)) u_act (
    .tgt       (tgt),
    .mode      (c_mode),
    .level     (c_level),
    .trig      (c_trig),
    .fixed_m   (fx_d),
    .smi_m     (smi_d),
    .nmi_m     (nmi_d),
    .init_m    (ini_d),
    .start_m   (st_d),
    .arbsync_m (arb_d)
  );

  // next state
  logic            valid_n;
  logic [NCPU-1:0] mask_n;
  logic [7:0]      vec_n;
  logic            trig_n;
  logic [NCPU-1:0] fx_n, smi_n, nmi_n, ini_n, st_n, arb_n;

  always_comb begin
    valid_n = cmd_lo_we;
    mask_n  = '0;
    vec_n   = '0;
    trig_n  = 1'b0;
    fx_n    = '0;
    smi_n   = '0;
    nmi_n   = '0;
    ini_n   = '0;
    st_n    = '0;
    arb_n   = '0;
    if (cmd_lo_we) begin
      mask_n = tgt;
      vec_n  = c_vec;
      trig_n = c_trig;
      fx_n   = fx_d;
      smi_n  = smi_d;
      nmi_n  = nmi_d;
      ini_n  = ini_d;
      st_n   = st_d;
      arb_n  = arb_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_mask    <= '0;
      res_vector  <= '0;
      res_trig    <= 1'b0;
      act_fixed   <= '0;
      act_smi     <= '0;
      act_nmi     <= '0;
      act_init    <= '0;
      act_start   <= '0;
      act_arbsync <= '0;
    end else begin
      res_valid   <= valid_n;
      res_mask    <= mask_n;
      res_vector  <= vec_n;
      res_trig    <= trig_n;
      act_fixed   <= fx_n;
      act_smi     <= smi_n;
      act_nmi     <= nmi_n;
      act_init    <= ini_n;
      act_start   <= st_n;
      act_arbsync <= arb_n;
    end
  end

  // assertions
  logic [NCPU-1:0] any_act;
  assign any_act = act_fixed | act_smi | act_nmi | act_init | act_start | act_arbsync;

  a_r1_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(cmd_lo_we));

  a_r6_only_populated: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_mask & ~$past(cpu_present)) == '0));

  a_r8_lowest_single: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cmd_lo[10:8]) == 3'd1) |-> $onehot0(res_mask));

  a_r7_one_action_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|act_fixed, |act_smi, |act_nmi, |act_init, |act_start, |act_arbsync}));

  a_r7_actions_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (any_act & ~res_mask) == '0);

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_mask == '0 && any_act == '0 && res_vector == '0 && !res_trig));

endmodule

// File: tb/sim_ipi_target_resolver.sv
`timescale 1ns/1ps
module sim_ipi_target_resolver;
  localparam int NCPU = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_lo_we;
  logic [31:0]       cmd_lo;
  logic [31:0]       cmd_hi;
  logic [1:0]        self_idx;
  logic [NCPU-1:0]   cpu_present;
  logic [NCPU*8-1:0] cpu_phys_id;
  logic [NCPU*8-1:0] cpu_log_id;
  logic [NCPU*4-1:0] cpu_fmt;
  logic              res_valid;
  logic [NCPU-1:0]   res_mask;
  logic [7:0]        res_vector;
  logic              res_trig;
  logic [NCPU-1:0]   act_fixed, act_smi, act_nmi, act_init, act_start, act_arbsync;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipi_target_resolver #(.NCPU(NCPU)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_lo_we(cmd_lo_we), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .self_idx(self_idx), .cpu_present(cpu_present), .cpu_phys_id(cpu_phys_id),
    .cpu_log_id(cpu_log_id), .cpu_fmt(cpu_fmt), .res_valid(res_valid),
    .res_mask(res_mask), .res_vector(res_vector), .res_trig(res_trig),
    .act_fixed(act_fixed), .act_smi(act_smi), .act_nmi(act_nmi),
    .act_init(act_init), .act_start(act_start), .act_arbsync(act_arbsync)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCPU-1:0] lowest(input logic [NCPU-1:0] m);
    for (int i = 0; i < NCPU; i++) if (m[i]) return NCPU'(1) << i;
    return '0;
  endfunction

  // expected resolved set before lowest-priority narrowing
  function automatic logic [NCPU-1:0] exp_set(input int sh, input int dm, input int dest, input int self);
    logic [NCPU-1:0] r = '0;
    if (sh == 1) begin
      if (cpu_present[self]) r[self] = 1'b1;
    end else if (sh == 2) begin
      r = cpu_present;
    end else if (sh == 3) begin
      r = cpu_present;
      r[self] = 1'b0;
    end else if (dm == 0) begin
      if (dest == 255) r = cpu_present;
      else begin
        for (int i = 0; i < NCPU; i++)
          if (cpu_present[i] && int'(cpu_phys_id[i*8 +: 8]) == dest && r == '0) r[i] = 1'b1;
      end
    end else begin
      for (int i = 0; i < NCPU; i++) begin
        int lid = int'(cpu_log_id[i*8 +: 8]);
        int f   = int'(cpu_fmt[i*4 +: 4]);
        if (!cpu_present[i]) continue;
        if (f == 15 && (dest & lid) != 0) r[i] = 1'b1;
        if (f == 0 && (dest / 16) == (lid / 16) && ((dest % 16) & (lid % 16)) != 0) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic string set_tag(input int sh, input int dm);
    if (sh != 0) return "R2 shorthand";
    if (dm == 0) return "R3 physical";
    return "R4 R5 logical";
  endfunction

  // issue one command, check result one cycle later
  task automatic run_cmd(input int sh, input int dm, input int dest, input int self,
                         input int mode, input int lvl, input int trg, input int vec);
    logic [NCPU-1:0] s, m, e_fx, e_smi, e_nmi, e_ini, e_st, e_arb;
    @(negedge clk);
    cmd_lo = 32'(vec) | (32'(mode) << 8) | (32'(dm) << 11) | (32'(lvl) << 14) |
             (32'(trg) << 15) | (32'(sh) << 18) | 32'h0000_3000;
    cmd_hi = (32'(dest) << 24) | 32'h00A5_5A5A;
    self_idx = 2'(self);
    cmd_lo_we = 1'b1;
    s = exp_set(sh, dm, dest, self);
    m = (mode == 1) ? lowest(s) : s;
    e_fx  = (mode == 0 || mode == 1) ? m : '0;
    e_smi = (mode == 2) ? m : '0;
    e_nmi = (mode == 4) ? m : '0;
    e_ini = (mode == 5 && !(lvl == 0 && trg == 1)) ? m : '0;
    e_arb = (mode == 5 && lvl == 0 && trg == 1) ? m : '0;
    e_st  = (mode == 6) ? m : '0;
    @(negedge clk);
    cmd_lo_we = 1'b0;
    chk("R1 valid strobe", 64'(res_valid), 64'd1);
    chk(mode == 1 ? "R8 lowest mask" : set_tag(sh, dm), 64'(res_mask), 64'(m));
    chk("R1 vector/trigger", 64'({res_vector, res_trig}), 64'({8'(vec), 1'(trg)}));
    chk(mode == 5 ? "R9 init/arbsync" : (mode == 1 ? "R8 fixed" : "R7 actions"),
        64'({act_fixed, act_smi, act_nmi, act_init, act_start, act_arbsync}),
        64'({e_fx, e_smi, e_nmi, e_ini, e_st, e_arb}));
  endtask

  task automatic load_cfg(input int cfg);
    if (cfg == 0) begin
      cpu_present = 4'b1111;
      cpu_phys_id = {8'h05, 8'h1A, 8'h05, 8'h00};
      cpu_log_id  = {8'h88, 8'h24, 8'h12, 8'h01};
      cpu_fmt     = {4'hF, 4'h0, 4'h0, 4'hF};
    end else begin
      cpu_present = 4'b1011;
      cpu_phys_id = {8'h30, 8'h31, 8'h32, 8'h33};
      cpu_log_id  = {8'h13, 8'h13, 8'h13, 8'h03};
      cpu_fmt     = {4'h0, 4'hF, 4'h7, 4'hF};
    end
  endtask

  task automatic idle_check(input string tag);
    chk(tag, 64'({res_valid, res_mask, res_vector, res_trig, act_fixed, act_smi,
                  act_nmi, act_init, act_start, act_arbsync}), 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_lo_we = 1'b0;
    cmd_lo = '0;
    cmd_hi = '0;
    self_idx = '0;
    load_cfg(0);
    repeat (3) @(negedge clk);
    idle_check("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R10 idle after reset");

    // R1: strobe timing, output not yet valid in the cycle of the write
    cmd_lo = 32'h0000_0042;
    cmd_hi = 32'hFF00_0000;
    cmd_lo_we = 1'b1;
    #1 chk("R1 not valid before edge", 64'(res_valid), 64'd0);
    @(negedge clk);
    cmd_lo_we = 1'b0;
    chk("R1 valid after edge", 64'(res_valid), 64'd1);
    chk("R7 fixed broadcast", 64'(act_fixed), 64'hF);
    @(negedge clk);
    idle_check("R10 single-cycle strobe");

    // directed: R9 level-deassert INIT vs normal INIT
    run_cmd(2, 0, 0, 1, 5, 0, 1, 8'h00);
    run_cmd(2, 0, 0, 1, 5, 1, 1, 8'h00);
    // directed: R8 lowest priority among others-shorthand
    run_cmd(3, 0, 0, 0, 1, 0, 0, 8'h31);
    // directed: R3 duplicated physical ID resolves to slot 1
    run_cmd(0, 0, 5, 0, 0, 0, 0, 8'h20);
    // directed: R6 self shorthand on an empty slot
    load_cfg(1);
    run_cmd(1, 0, 0, 2, 0, 0, 0, 8'h21);
    chk("R6 empty self slot", 64'(res_mask), 64'd0);

    // sweeps
    for (int cfg = 0; cfg < 2; cfg++) begin
      load_cfg(cfg);
      for (int sh = 0; sh < 4; sh++)
        for (int dm = 0; dm < 2; dm++)
          for (int d = 0; d < 256; d++)
            run_cmd(sh, dm, d, d % 4, d % 8, (d / 8) % 2, (d / 16) % 2, (d * 7 + sh) % 256);
      @(negedge clk);
      idle_check("R10 idle after sweep");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule